// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block chooses the fastest DMA transfer mode that a host controller and an attached storage device both support. Software or a control sequencer presents three things. The first is the capability words the device reported: a validity word, the UltraDMA, multiword and single-word mode words, and a legacy timing byte. The second is the host's own per-family support masks. The third is a requested mode code, which acts as a ceiling. It then pulses `start`. The block returns a mode code, or zero when no DMA mode is usable. It also returns a flag that marks the reported capability data as self-contradictory.

The search is sequential. It visits one mode family per clock cycle, in a fixed priority order, and it stops at the first family that yields a mode. Several rules shape the search. A cable-detect input limits the UltraDMA modes. When a device sets no validity bit for the DMA words, its legacy timing byte can still enable single-word DMA. The final code never exceeds the requested code. Mode codes use these family bases: 0x40 for UltraDMA, 0x20 for multiword DMA and 0x10 for single-word DMA. Within a family, the mode number is added to its base.

Top module: `dma_mode_selector`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `bad_caps` are 0 and `mode_out` is 0x00.
- R2: A `start` seen while idle captures all inputs and raises `busy`. `done` then pulses for exactly one cycle, at most 3 cycles after the capture edge, and `busy` is low in that cycle. A `start` seen while `busy` is ignored. `mode_out` and `bad_caps` hold their values until the next `done`.
- R3: The families are tried in the order UltraDMA (base 0x40), multiword (base 0x20), then single-word (base 0x10). A family is skipped when the requested code is below its base. The first family with a nonzero mask supplies the mode.
- R4: A family's mask is the host mask ANDed with the low byte of the device's word for that family. Its mode is the family base plus the index of the mask's highest set bit.
- R5: The UltraDMA family is usable only when validity bit 2 is set. The multiword family is usable only when validity bit 1 is set. The single-word family uses the device word only when validity bit 1 is set.
- R6: When the requested code is above 0x42, the UltraDMA mask has any bit in 0x78, and `cable80` is 0, the UltraDMA mask is reduced to its bits in 0x07.
- R7: When validity bit 1 is clear and the legacy timing byte L is 1 or 2, the single-word mask is ((2 << L) - 1) ANDed with the host single-word mask. Any other value of L gives an empty single-word mask.
- R8: `mode_out` is the smaller of the selected mode and the requested code.
- R9: When `is_disk` is 0 and `host_no_pkt_dma` is 1, `mode_out` is 0x00.
- R10: `bad_caps` is 1 in two cases. The first: validity bit 2 is set and the high bytes of both the UltraDMA and multiword words are nonzero. The second: validity bit 2 is clear, validity bit 1 is set, and the high bytes of both the multiword and single-word words are nonzero.
- R11: When no family yields a nonzero mask, `mode_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection with the current inputs |
| req_mode | input | 8 | Requested (ceiling) mode code |
| is_disk | input | 1 | Device is a disk rather than a packet device |
| host_no_pkt_dma | input | 1 | Host forbids DMA for packet devices |
| cable80 | input | 1 | 80-wire cable detected |
| dev_valid | input | 16 | Device validity word (bit 1: DMA words, bit 2: UltraDMA word) |
| dev_ultra | input | 16 | Device UltraDMA word; low byte is the supported modes |
| dev_multi | input | 16 | Device multiword DMA word |
| dev_single | input | 16 | Device single-word DMA word |
| dev_legacy | input | 8 | Legacy single-word timing mode byte |
| host_ultra | input | 8 | Host UltraDMA support mask |
| host_multi | input | 8 | Host multiword support mask |
| host_single | input | 8 | Host single-word support mask |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle pulse: result updated |
| mode_out | output | 8 | Selected mode code, 0 for none |
| bad_caps | output | 1 | Capability data is contradictory |

## Verification
The hardest path to reach is the one where the cable cap empties the UltraDMA mask and the search falls through to multiword DMA. To get there, the device must report only modes 3 to 6, there must be no 80-wire cable, and the request must be above UltraDMA 2. The bench sets up exactly that combination. It also issues a second `start` one cycle into a running search, which shows that the request is ignored and that the first result is held. The else-if ordering of the two contradiction rules is reached with a device that sets both validity bits. That device has nonzero high bytes in its multiword and single-word words but not in its UltraDMA word, and it must not be flagged.

// File: rtl/dma_mode_pkg.sv
package dma_mode_pkg;

    localparam int MODE_W  = 8;
    localparam int MASK_W  = 8;
    localparam int CAP_W   = 16;
    localparam int IDX_W   = $clog2(MASK_W);
    localparam int NUM_FAM = 3;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [CAP_W-1:0]  cap_t;

    typedef enum logic [1:0] {
        FAM_ULTRA  = 2'd0,
        FAM_MULTI  = 2'd1,
        FAM_SINGLE = 2'd2
    } family_e;

    localparam int VALID_ULTRA_BIT = 2;
    localparam int VALID_DMA_BIT   = 1;

    localparam mode_t BASE_ULTRA  = 8'h40;
    localparam mode_t BASE_MULTI  = 8'h20;
    localparam mode_t BASE_SINGLE = 8'h10;
    localparam mode_t ULTRA_CAP_LIMIT = 8'h42;
    localparam mask_t ULTRA_FAST_BITS = 8'h78;
    localparam mask_t ULTRA_SLOW_BITS = 8'h07;
    localparam logic [7:0] LEGACY_MAX = 8'd2;

    typedef struct packed {
        cap_t       valid;
        cap_t       ultra;
        cap_t       multi;
        cap_t       single;
        logic [7:0] legacy;
    } dev_caps_t;

    typedef struct packed {
        mask_t ultra;
        mask_t multi;
        mask_t single;
    } host_masks_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } top_bit_t;

    function automatic mode_t fam_base(input family_e f);
        case (f)
            FAM_ULTRA:  return BASE_ULTRA;
            FAM_MULTI:  return BASE_MULTI;
            default:    return BASE_SINGLE;
        endcase
    endfunction

    function automatic top_bit_t find_top(input mask_t m);
        top_bit_t r;
        r = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (m[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic hi_nz(input cap_t w);
        return |w[CAP_W-1:MASK_W];
    endfunction

endpackage

// File: rtl/dma_caps_check.sv
module dma_caps_check
    import dma_mode_pkg::*;
(
    input  dev_caps_t caps,
    output logic      bad
);
    always_comb begin
        if (caps.valid[VALID_ULTRA_BIT])
            bad = hi_nz(caps.ultra) && hi_nz(caps.multi);
        else if (caps.valid[VALID_DMA_BIT])
            bad = hi_nz(caps.multi) && hi_nz(caps.single);
        else
            bad = 1'b0;
    end
endmodule

// File: rtl/dma_family_mask.sv
module dma_family_mask
    import dma_mode_pkg::*;
#(
    parameter int FAM = 0
) (
    input  dev_caps_t   caps,
    input  host_masks_t host,
    input  mode_t       req,
    input  logic        cable80,
    input  logic        blocked,
    output mask_t       mask
);
    mask_t raw;

    generate
        if (FAM == 0) begin : g_ultra
            always_comb begin
                raw = '0;
                if (caps.valid[VALID_ULTRA_BIT]) begin
                    raw = host.ultra & caps.ultra[MASK_W-1:0];
                    if (req > ULTRA_CAP_LIMIT && |(raw & ULTRA_FAST_BITS) && !cable80)
                        raw = raw & ULTRA_SLOW_BITS;
                end
            end
        end else if (FAM == 1) begin : g_multi
            always_comb begin
                raw = '0;
                if (caps.valid[VALID_DMA_BIT])
                    raw = host.multi & caps.multi[MASK_W-1:0];
            end
        end else begin : g_single
            always_comb begin
                raw = '0;
                if (caps.valid[VALID_DMA_BIT])
                    raw = host.single & caps.single[MASK_W-1:0];
                else if (caps.legacy != 8'd0 && caps.legacy <= LEGACY_MAX)
                    raw = mask_t'((9'd2 << caps.legacy[1:0]) - 9'd1) & host.single;
            end
        end
    endgenerate

    assign mask = (blocked || req < fam_base(family_e'(FAM))) ? '0 : raw;
endmodule

// File: rtl/dma_mode_selector.sv
module dma_mode_selector
    import dma_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  req_mode,
    input  logic        is_disk,
    input  logic        host_no_pkt_dma,
    input  logic        cable80,
    input  logic [15:0] dev_valid,
    input  logic [15:0] dev_ultra,
    input  logic [15:0] dev_multi,
    input  logic [15:0] dev_single,
    input  logic [7:0]  dev_legacy,
    input  logic [7:0]  host_ultra,
    input  logic [7:0]  host_multi,
    input  logic [7:0]  host_single,
    output logic        busy,
    output logic        done,
    output logic [7:0]  mode_out,
    output logic        bad_caps
);
    typedef enum logic {ST_IDLE, ST_SCAN} state_e;

    state_e      state;
    family_e     fam;
    dev_caps_t   caps_q;
    host_masks_t host_q;
    mode_t       req_q;
    logic        cable_q;
    logic        blocked_q;
    mask_t       fam_mask [NUM_FAM];
    mask_t       cur_mask;
    top_bit_t    top;
    mode_t       cand;
    mode_t       clamped;
    logic        bad_now;

    genvar g;
    generate
        for (g = 0; g < NUM_FAM; g++) begin : g_fam
            dma_family_mask #(.FAM(g)) u_mask (
                .caps    (caps_q),
                .host    (host_q),
                .req     (req_q),
                .cable80 (cable_q),
                .blocked (blocked_q),
                .mask    (fam_mask[g])
            );
        end
    endgenerate

    dma_caps_check u_check (
        .caps (caps_q),
        .bad  (bad_now)
    );

    always_comb begin
        case (fam)
            FAM_ULTRA: cur_mask = fam_mask[0];
            FAM_MULTI: cur_mask = fam_mask[1];
            default:   cur_mask = fam_mask[2];
        endcase
        top     = find_top(cur_mask);
        cand    = fam_base(fam) + mode_t'(top.idx);
        clamped = (cand < req_q) ? cand : req_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            fam       <= FAM_ULTRA;
            caps_q    <= '0;
            host_q    <= '0;
            req_q     <= '0;
            cable_q   <= 1'b0;
            blocked_q <= 1'b0;
            done      <= 1'b0;
            mode_out  <= '0;
            bad_caps  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        caps_q    <= '{valid: dev_valid, ultra: dev_ultra, multi: dev_multi,
                                       single: dev_single, legacy: dev_legacy};
                        host_q    <= '{ultra: host_ultra, multi: host_multi, single: host_single};
                        req_q     <= req_mode;
                        cable_q   <= cable80;
                        blocked_q <= !is_disk && host_no_pkt_dma;
                        fam       <= FAM_ULTRA;
                        state     <= ST_SCAN;
                    end
                end
                default: begin
                    if (top.hit || fam == FAM_SINGLE) begin
                        mode_out <= top.hit ? clamped : '0;
                        bad_caps <= bad_now;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        fam <= family_e'(fam + 2'd1);
                    end
                end
            endcase
        end
    end

    assign busy = (state == ST_SCAN);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));
    assert_clamp_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (mode_out <= req_q));
    assert_pkt_block_R9: assert property (@(posedge clk) disable iff (rst)
        (done && blocked_q) |-> (mode_out == 8'h00));
    assert_cable_cap_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !cable_q && req_q > 8'h42) |-> !(mode_out > 8'h42 && mode_out < 8'h48));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(mode_out));
endmodule

// File: tb/dma_mode_selector_tb.sv
module dma_mode_selector_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  req_mode = '0;
    logic        is_disk = 1'b1, host_no_pkt_dma = 1'b0, cable80 = 1'b1;
    logic [15:0] dev_valid = '0, dev_ultra = '0, dev_multi = '0, dev_single = '0;
    logic [7:0]  dev_legacy = '0, host_ultra = '0, host_multi = '0, host_single = '0;
    logic        busy, done, bad_caps;
    logic [7:0]  mode_out;

    int n_checks = 0, n_fail = 0, n_done = 0, n_pushed = 0;
    logic [8:0]  exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_mode_selector u_dut (
        .clk(clk), .rst(rst), .start(start), .req_mode(req_mode),
        .is_disk(is_disk), .host_no_pkt_dma(host_no_pkt_dma), .cable80(cable80),
        .dev_valid(dev_valid), .dev_ultra(dev_ultra), .dev_multi(dev_multi),
        .dev_single(dev_single), .dev_legacy(dev_legacy),
        .host_ultra(host_ultra), .host_multi(host_multi), .host_single(host_single),
        .busy(busy), .done(done), .mode_out(mode_out), .bad_caps(bad_caps)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int top_idx(input logic [7:0] m);
        int r = -1;
        for (int i = 0; i < 8; i++) if (m[i]) r = i;
        return r;
    endfunction

    function automatic logic [8:0] model();
        logic [7:0] m, best;
        logic bad;
        best = 8'h00;
        if (dev_valid[2]) bad = (dev_ultra[15:8] != 0) && (dev_multi[15:8] != 0);
        else if (dev_valid[1]) bad = (dev_multi[15:8] != 0) && (dev_single[15:8] != 0);
        else bad = 1'b0;
        if (!(!is_disk && host_no_pkt_dma)) begin
            if (req_mode >= 8'h40 && dev_valid[2]) begin
                m = host_ultra & dev_ultra[7:0];
                if (req_mode > 8'h42 && (m & 8'h78) != 0 && !cable80) m = m & 8'h07;
                if (m != 0) best = 8'h40 + 8'(top_idx(m));
            end
            if (best == 0 && req_mode >= 8'h20 && dev_valid[1]) begin
                m = host_multi & dev_multi[7:0];
                if (m != 0) best = 8'h20 + 8'(top_idx(m));
            end
            if (best == 0 && req_mode >= 8'h10) begin
                if (dev_valid[1]) m = host_single & dev_single[7:0];
                else if (dev_legacy == 1) m = 8'h03 & host_single;
                else if (dev_legacy == 2) m = 8'h07 & host_single;
                else m = 8'h00;
                if (m != 0) best = 8'h10 + 8'(top_idx(m));
            end
        end
        if (best > req_mode) best = req_mode;
        return {bad, best};
    endfunction

    task automatic wait_done(input string tag);
        int cyc = 0;
        while (!done && cyc < 10) begin
            @(negedge clk);
            cyc++;
        end
        check({tag, " R2 latency"}, 32'(cyc <= 3), 32'd1);
    endtask

    // Driver: pushes the expected item, then issues the request
    task automatic run(input string tag, input logic [7:0] rq, input logic [15:0] v,
                       input logic [15:0] du, dm, ds, input logic [7:0] lg,
                       input logic [7:0] hu, hm, hs, input logic cab, disk, nopkt);
        @(negedge clk);
        req_mode = rq; dev_valid = v; dev_ultra = du; dev_multi = dm; dev_single = ds;
        dev_legacy = lg; host_ultra = hu; host_multi = hm; host_single = hs;
        cable80 = cab; is_disk = disk; host_no_pkt_dma = nopkt;
        exp_q.push_back(model()); tag_q.push_back(tag); n_pushed++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 busy"}, 32'(busy), 32'd1);
        wait_done(tag);
    endtask

    // Monitor: pops and compares on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                check("R2 unexpected done", 32'd1, 32'd0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {23'd0, bad_caps, mode_out}, {23'd0, e});
            end
        end
    end

    logic timed_out = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                check("R1 reset done", 32'(done), 32'd0);
                check("R1 reset busy", 32'(busy), 32'd0);
                check("R1 reset mode", 32'(mode_out), 32'd0);
                check("R1 reset bad", 32'(bad_caps), 32'd0);
                //   tag            req    valid  ultra    multi    single   leg  hu     hm     hs    cab disk nopkt
                run("R4 top udma",   8'h46, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R8 clamp udma", 8'h45, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R4 host and",   8'h46, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h0F, 8'h07, 8'h07, 1, 1, 0);
                run("R6 cable cap",  8'h46, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 0, 1, 0);
                run("R6 cap to mw",  8'h46, 16'h6, 16'h0078, 16'h0003, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 0, 1, 0);
                run("R6 no cap lo",  8'h42, 16'h6, 16'h0078, 16'h0003, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 0, 1, 0);
                run("R5 no udma vb", 8'h46, 16'h2, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R3 skip udma",  8'h22, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R8 clamp mw",   8'h21, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R3 sw only",    8'h12, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R3 below all",  8'h0C, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R3 mw empty sw",8'h46, 16'h2, 16'h0000, 16'h0000, 16'h0004, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R7 legacy 1",   8'h46, 16'h0, 16'h0000, 16'h0000, 16'h0000, 1, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R7 legacy 2",   8'h46, 16'h0, 16'h0000, 16'h0000, 16'h0000, 2, 8'h7F, 8'h07, 8'h03, 1, 1, 0);
                run("R7 legacy 3",   8'h46, 16'h0, 16'h0000, 16'h0000, 16'h0000, 3, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R5 vb1 no leg", 8'h46, 16'h2, 16'h0000, 16'h0000, 16'h0000, 2, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R9 pkt block",  8'h46, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 0, 1);
                run("R9 pkt allowed",8'h46, 16'h6, 16'h007F, 16'h0007, 16'h0007, 0, 8'h7F, 8'h07, 8'h07, 1, 0, 0);
                run("R10 bad udma",  8'h46, 16'h4, 16'h0101, 16'h0101, 16'h0000, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R10 bad dma",   8'h46, 16'h2, 16'h0000, 16'h0101, 16'h0101, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R10 else-if",   8'h46, 16'h6, 16'h0001, 16'h0101, 16'h0101, 0, 8'h7F, 8'h07, 8'h07, 1, 1, 0);
                run("R11 disjoint",  8'h46, 16'h6, 16'h0070, 16'h0004, 16'h0004, 0, 8'h0F, 8'h03, 8'h03, 1, 1, 0);
                // R2: a second start while busy is ignored and the result holds
                @(negedge clk);
                req_mode = 8'h46; dev_valid = 16'h6; dev_ultra = 16'h0007; dev_multi = 16'h0;
                dev_single = 16'h0; dev_legacy = 0; host_ultra = 8'h7F; host_multi = 8'h07;
                host_single = 8'h07; cable80 = 1; is_disk = 1; host_no_pkt_dma = 0;
                exp_q.push_back(model()); tag_q.push_back("R2 first wins"); n_pushed++;
                start = 1'b1;
                @(negedge clk);
                req_mode = 8'h21; dev_ultra = 16'h0001;
                @(negedge clk);
                start = 1'b0;
                wait_done("R2 ignore");
                repeat (4) begin
                    @(negedge clk);
                    check("R2 no extra done", 32'(done), 32'd0);
                    check("R2 hold mode", 32'(mode_out), 32'h42);
                end
                check("R2 done count", 32'(n_done), 32'(n_pushed));
                check("R2 queue empty", 32'(exp_q.size()), 32'd0);
            end
            begin
                wait (timed_out);
                check("watchdog", 32'd1, 32'd0);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule